// File: doc/BRIEF.md
# Four-Point Fixed-Point Inverse DCT Unit

This block performs a reduced 4-point inverse discrete cosine transform on one vector of four signed 16-bit coefficients per transaction. The even part forms the sum and difference of coefficients 0 and 2. The odd part uses one shared rotation product, scaled by 4433, and combines it with coefficient 1 scaled by 6270 and coefficient 3 scaled by 15137. The two parts then meet in a final butterfly.

There are two modes, chosen per vector. Column mode is the first pass of a separable 2-D transform. It rounds the odd products by 1024, shifts them right by 11 and adds them to the even terms scaled by four. It emits four signed 16-bit intermediates that wrap without saturation. Row mode is the second pass. It biases coefficient 0 by 4112, which folds together rounding and the +128 level shift. Each result is formed as (even·8192 ± odd) shifted arithmetically right by 18 and clamped to an 8-bit pixel.

Vectors enter through a valid/ready handshake. Each result sits in a single output register until the consumer takes it. The mode travels alongside the result.

Top module: `idct4_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid` is low after that edge.
- R2: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_mode` keep their values.
- R3: A vector accepted at a rising edge (`in_valid` and `in_ready` both high) has its result presented with `out_valid` high right after that edge. If nothing is accepted and nothing is held, `out_valid` is low after the edge.
- R4: Column mode (`in_mode`=0) works as follows. Let d0..d3 be the coefficients, with dk in `in_coef[16k+15:16k]`. The terms are z = (d1+d3)·4433 + 1024, p = z + d1·6270 and q = z − d3·15137. The outputs are o0 = 4(d0+d2) + (p>>>11), o3 = 4(d0+d2) − (p>>>11), o1 = 4(d0−d2) + (q>>>11) and o2 = 4(d0−d2) − (q>>>11).
- R5: Column-mode outputs are the low 16 bits of the exact results, with no saturation, so large inputs wrap.
- R6: Row mode (`in_mode`=1) works as follows. Let b = d0 + 4112 and z = (d1+d3)·4433, and form p and q from z as in R4. The outputs are o0/o3 = (8192(b+d2) ± p)>>>18 and o1/o2 = (8192(b−d2) ± q)>>>18.
- R7: Row-mode results clamp to 0..255. Negative values give 0 and values above 255 give 255. Bits 15:8 of every lane are zero.
- R8: `out_mode` equals the `in_mode` that was sampled with the vector being presented.
- R9: Output k of the transform occupies `out_data[16k+15:16k]`, in the order o0, o1, o2, o3 from the low lane.
- R10: In row mode with d1=d2=d3=0, all four pixels are equal to the clamp of (d0+4112)>>>5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input vector valid |
| in_ready | output | 1 | Unit can take a vector this cycle |
| in_mode | input | 1 | 0 = column pass, 1 = row pass |
| in_coef | input | 64 | Four signed coefficients, d0 in the low lane |
| out_valid | output | 1 | Result vector valid |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_mode | output | 1 | Mode of the presented result |
| out_data | output | 64 | Four 16-bit result lanes, o0 in the low lane |

## Verification
A result is due one edge after its acceptance. It then stays in place for every further edge at which `out_ready` is low, and the slot frees at the edge where `out_ready` is high.

The bench drives inputs and decides acceptance just after each falling edge, from its own view of whether the slot is occupied. It queues the expected lanes and mode at that moment. At the next falling edge it compares `out_valid`, `out_mode` and all four lanes against the head of the queue. The model is therefore checked against outputs that have settled after exactly one rising edge.

Stalls are produced by holding `out_ready` low. Every stalled cycle re-checks the held result and also checks `in_ready`.

// File: rtl/idct4_pkg.sv
package idct4_pkg;

    localparam int COEF_W  = 16;
    localparam int LANES   = 4;
    localparam int PIX_W   = 8;
    localparam int ACC_W   = 34;
    localparam int BUS_W   = COEF_W * LANES;

    localparam int K_ROT   = 4433;
    localparam int K_ODD_A = 6270;
    localparam int K_ODD_B = 15137;
    localparam int COL_RND = 1024;
    localparam int ROW_DC  = 4112;
    localparam int COL_PRE = 2;
    localparam int COL_SHR = 11;
    localparam int ROW_PRE = 13;
    localparam int ROW_SHR = 18;
    localparam int PIX_MAX = (1 << PIX_W) - 1;

    typedef enum logic {
        PASS_COL = 1'b0,
        PASS_ROW = 1'b1
    } pass_e;

    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    typedef struct packed {
        acc_t sum;
        acc_t dif;
    } even_t;

    typedef struct packed {
        acc_t upper;
        acc_t lower;
    } odd_t;

    function automatic acc_t widen(input coef_t v);
        return acc_t'(v);
    endfunction

    function automatic logic [PIX_W-1:0] clamp_pix(input acc_t v);
        if (v < 0)
            return '0;
        else if (v > acc_t'(PIX_MAX))
            return PIX_W'(PIX_MAX);
        else
            return v[PIX_W-1:0];
    endfunction

endpackage

// File: rtl/idct4_even.sv
module idct4_even
    import idct4_pkg::*;
(
    input  coef_t d0,
    input  coef_t d2,
    input  pass_e mode,
    output even_t ev
);
    acc_t base;
    acc_t side;

    always_comb begin
        base = widen(d0);
        if (mode == PASS_ROW)
            base = base + acc_t'(ROW_DC);
        side   = widen(d2);
        ev.sum = base + side;
        ev.dif = base - side;
    end
endmodule

// File: rtl/idct4_odd.sv
module idct4_odd
    import idct4_pkg::*;
(
    input  coef_t d1,
    input  coef_t d3,
    input  pass_e mode,
    output odd_t  od
);
    localparam acc_t C_ROT = acc_t'(K_ROT);
    localparam acc_t C_A   = acc_t'(K_ODD_A);
    localparam acc_t C_B   = acc_t'(K_ODD_B);

    acc_t a1;
    acc_t a3;
    acc_t shared;

    always_comb begin
        a1     = widen(d1);
        a3     = widen(d3);
        shared = (a1 + a3) * C_ROT;
        if (mode == PASS_COL)
            shared = shared + acc_t'(COL_RND);
        od.upper = shared + a1 * C_A;
        od.lower = shared - a3 * C_B;
    end
endmodule

// File: rtl/idct4_combine.sv
module idct4_combine
    import idct4_pkg::*;
(
    input  even_t              ev,
    input  odd_t               od,
    input  pass_e              mode,
    output logic [BUS_W-1:0]   lanes
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam bit OUTER = (k == 0) || (k == LANES - 1);
        localparam bit SUBT  = (k >= LANES / 2);

        acc_t e_sel;
        acc_t o_sel;
        acc_t col_val;
        acc_t row_val;

        always_comb begin
            e_sel = OUTER ? ev.sum   : ev.dif;
            o_sel = OUTER ? od.upper : od.lower;
            if (SUBT) begin
                col_val = (e_sel <<< COL_PRE) - (o_sel >>> COL_SHR);
                row_val = ((e_sel <<< ROW_PRE) - o_sel) >>> ROW_SHR;
            end else begin
                col_val = (e_sel <<< COL_PRE) + (o_sel >>> COL_SHR);
                row_val = ((e_sel <<< ROW_PRE) + o_sel) >>> ROW_SHR;
            end
            if (mode == PASS_ROW)
                lanes[k*COEF_W +: COEF_W] = {{(COEF_W-PIX_W){1'b0}}, clamp_pix(row_val)};
            else
                lanes[k*COEF_W +: COEF_W] = col_val[COEF_W-1:0];
        end
    end
endmodule

// File: rtl/idct4_unit.sv
module idct4_unit
    import idct4_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_mode,
    input  logic [BUS_W-1:0]  in_coef,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_mode,
    output logic [BUS_W-1:0]  out_data
);
    pass_e             mode_in;
    even_t             ev;
    odd_t              od;
    logic [BUS_W-1:0]  lanes;
    logic              take;

    assign mode_in  = pass_e'(in_mode);
    assign in_ready = !out_valid || out_ready;
    assign take     = in_valid && in_ready;

    idct4_even u_even (
        .d0   (coef_t'(in_coef[0*COEF_W +: COEF_W])),
        .d2   (coef_t'(in_coef[2*COEF_W +: COEF_W])),
        .mode (mode_in),
        .ev   (ev)
    );

    idct4_odd u_odd (
        .d1   (coef_t'(in_coef[1*COEF_W +: COEF_W])),
        .d3   (coef_t'(in_coef[3*COEF_W +: COEF_W])),
        .mode (mode_in),
        .od   (od)
    );

    idct4_combine u_comb (
        .ev    (ev),
        .od    (od),
        .mode  (mode_in),
        .lanes (lanes)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else if (take) begin
            out_valid <= 1'b1;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (take) begin
            out_data <= lanes;
            out_mode <= in_mode;
        end
    end
endmodule

// File: rtl/idct4_unit_chk.sv
module idct4_unit_chk
    import idct4_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_mode,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_mode,
    input logic [BUS_W-1:0] out_data
);
    p_reset_clear_r1: assert property (@(posedge clk) rst |=> !out_valid);

    p_hold_stall_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_mode)));

    p_stall_blocks_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    p_accept_next_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    p_drain_r3: assert property (@(posedge clk) disable iff (rst)
        (!(in_valid && in_ready) && !(out_valid && !out_ready)) |=> !out_valid);

    p_pixel_range_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_mode) |->
        (out_data[15:8] == 8'h0 && out_data[31:24] == 8'h0 &&
         out_data[47:40] == 8'h0 && out_data[63:56] == 8'h0));

    p_mode_echo_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (out_mode == $past(in_mode)));
endmodule

bind idct4_unit idct4_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_mode   (in_mode),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_mode  (out_mode),
    .out_data  (out_data)
);

// File: tb/tb_idct4_unit.sv
module tb_idct4_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic        in_mode;
    logic [63:0] in_coef;
    logic        out_valid;
    logic        out_ready;
    logic        out_mode;
    logic [63:0] out_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;
    int cyc   = 0;

    typedef struct {
        logic [63:0] data;
        logic        mode;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    idct4_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_mode(in_mode), .in_coef(in_coef), .out_valid(out_valid),
        .out_ready(out_ready), .out_mode(out_mode), .out_data(out_data)
    );

    function automatic logic [63:0] model(input logic row, input logic [63:0] c);
        longint d[4];
        longint z, p, q0, e0, e1, v;
        longint o[4];
        logic [63:0] r;
        for (int k = 0; k < 4; k++) d[k] = longint'($signed(c[16*k +: 16]));
        if (row) d[0] = d[0] + 4112;
        z = (d[1] + d[3]) * 4433;
        if (!row) z = z + 1024;
        p  = z + d[1] * 6270;
        q0 = z - d[3] * 15137;
        e0 = d[0] + d[2];
        e1 = d[0] - d[2];
        if (!row) begin
            o[0] = e0 * 4 + (p >>> 11);
            o[3] = e0 * 4 - (p >>> 11);
            o[1] = e1 * 4 + (q0 >>> 11);
            o[2] = e1 * 4 - (q0 >>> 11);
        end else begin
            o[0] = (e0 * 8192 + p) >>> 18;
            o[3] = (e0 * 8192 - p) >>> 18;
            o[1] = (e1 * 8192 + q0) >>> 18;
            o[2] = (e1 * 8192 - q0) >>> 18;
            for (int k = 0; k < 4; k++) begin
                v = o[k];
                if (v < 0) v = 0;
                if (v > 255) v = 255;
                o[k] = v;
            end
        end
        for (int k = 0; k < 4; k++) r[16*k +: 16] = o[k][15:0];
        return r;
    endfunction

    function automatic logic [63:0] pack4(input int a, input int b, input int c, input int d);
        return {16'(d), 16'(c), 16'(b), 16'(a)};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // At negedge: compare outputs, then drive next inputs and update model.
    task automatic step(input logic v, input logic m, input logic [63:0] c,
                        input logic ordy, input string tag);
        @(negedge clk);
        check("R3 out_valid", 64'(out_valid), 64'(q.size() != 0));
        if (q.size() != 0 && out_valid) begin
            check({q[0].tag, " R9 lanes"}, out_data, q[0].data);
            check("R8 out_mode", 64'(out_mode), 64'(q[0].mode));
        end
        in_valid  = v;
        in_mode   = m;
        in_coef   = c;
        out_ready = ordy;
        #1;
        check("R2 in_ready", 64'(in_ready), 64'(q.size() == 0 || ordy));
        if (q.size() != 0 && ordy) void'(q.pop_front());
        if (v && (q.size() == 0)) begin
            exp_t e;
            e.data = model(m, c);
            e.mode = m;
            e.tag  = tag;
            q.push_back(e);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        rst = 1; in_valid = 0; in_mode = 0; in_coef = '0; out_ready = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset out_valid", 64'(out_valid), 64'(0));
        rst = 0;

        // R4 column math, several patterns
        step(1, 0, pack4(100, 0, 0, 0),       1, "R4 dc");
        step(1, 0, pack4(10, 20, -30, 40),    1, "R4 mix");
        step(1, 0, pack4(-512, 300, 7, -900), 1, "R4 neg");
        step(1, 0, pack4(0, 1000, 0, 0),      1, "R4 odd-only");
        // R5 wrap without saturation
        step(1, 0, pack4(32767, 0, 32767, 0), 1, "R5 wrap pos");
        step(1, 0, pack4(-32768, 32767, -32768, 32767), 1, "R5 wrap neg");
        // R6 row math
        step(1, 1, pack4(800, -200, 150, 60), 1, "R6 row mix");
        step(1, 1, pack4(0, 0, 0, 0),         1, "R6 row zero");
        // R7 clamp both ends
        step(1, 1, pack4(-9000, 0, 0, 0),     1, "R7 clamp low");
        step(1, 1, pack4(9000, 0, 0, 0),      1, "R7 clamp high");
        step(1, 1, pack4(0, 6000, 0, -6000),  1, "R7 clamp split");
        // R10 DC-only row
        step(1, 1, pack4(-1234, 0, 0, 0),     1, "R10 dc row");
        step(0, 0, '0, 1, "idle");
        @(negedge clk);
        check("R10 equal pixels", model(1, pack4(-1234, 0, 0, 0)),
              {4{16'(((-1234 + 4112) >>> 5))}});

        // R2 stall: hold result with out_ready low, offered input must be refused
        step(1, 1, pack4(500, 40, -60, 10), 0, "R2 held");
        step(1, 0, pack4(1, 2, 3, 4), 0, "R2 refused");
        step(1, 0, pack4(1, 2, 3, 4), 0, "R2 refused");
        step(1, 0, pack4(5, 6, 7, 8), 1, "R2 after stall");
        step(0, 0, '0, 1, "drain");
        step(0, 0, '0, 1, "R3 empty");

        // mixed traffic with random backpressure
        for (int i = 0; i < 400; i++) begin
            logic [63:0] c;
            c = {$urandom, $urandom};
            step(1'($urandom), 1'($urandom), c, 1'($urandom), "R4R6 random");
        end
        step(0, 0, '0, 1, "flush");
        step(0, 0, '0, 1, "flush");
        @(negedge clk);
        summary();
    end
endmodule